// File: doc/BRIEF.md
# Indexed Bit and Rotate Execution Unit

This unit executes the four-byte indexed bit-manipulation instruction form: an index prefix, the 0xCB escape, a signed displacement byte and a final operation byte. Fetching the instruction and decoding the prefix happen elsewhere. When started, the unit receives the operation byte, the displacement, the current index register value and the carry flag. It reads the operand byte at index plus displacement, applies the selected operation, and, for every operation that changes the byte, writes the result back to the same location.

The unit also copies the modified byte into a general register chosen by the low three bits of the operation byte. The code 110 means the result goes to memory only. Bit tests touch neither memory nor registers, whatever their low bits hold. Flags are produced as for the equivalent single-register operation. Memory is reached through a request/acknowledge handshake, registers through a one-cycle write strobe, and flags through a one-cycle flag-update strobe.

Top module: `xbit_unit`

## Requirements
- R1: The operand address is `index_base` plus the sign-extended `disp_byte`, taken modulo 2^ADDR_W. The first memory access of every instruction is a single read of that address.
- R2: `op_byte[7:6]` selects the class: 00 shift/rotate, 01 bit test, 10 bit reset, 11 bit set. For test, reset and set, `op_byte[5:3]` is the bit index. Reset clears that bit of the operand and set raises it.
- R3: In the shift class, `op_byte[5:3]` picks the operation: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 arithmetic left shift with 0 into bit 0, 5 arithmetic right shift keeping bit 7, 6 left shift with bit 0 forced to 1, 7 logical right shift. The bit shifted out becomes the new carry.
- R4: Shift, reset and set write the result exactly once to the operand address, after the read.
- R5: When `op_byte[2:0]` is not 110, shift, reset and set pulse `rf_we` in the same cycle as `done`, with `rf_sel = op_byte[2:0]` (000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A) and `rf_wdata` equal to the computed result. This holds even when the memory write is discarded.
- R6: When `op_byte[2:0]` is 110, no register write occurs.
- R7: A bit test writes neither memory nor any register, for every value of `op_byte[2:0]`. It pulses `flags_we` with Z = P = inverted tested bit, H = 1, N = 0, S = tested bit when the index is 7 (else 0), Y = X = 0, and C = `carry_in`.
- R8: Shift-class flags: S = result bit 7, Z = result is zero, Y = result bit 5, H = 0, X = result bit 3, P = 1 for even parity of the result, N = 0, C = bit shifted out. The `flags_out` layout is bit 7 S, 6 Z, 5 Y, 4 H, 3 X, 2 P, 1 N, 0 C.
- R9: Reset and set do not pulse `flags_we`.
- R10: While `mem_req` is high and `mem_ack` is low, the request, address, direction and write data stay unchanged. A `start` pulse arriving while `busy` is high is ignored.
- R11: After reset, `busy`, `mem_req`, `rf_we`, `flags_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| op_byte | input | 8 | Final operation byte |
| disp_byte | input | 8 | Signed displacement |
| index_base | input | ADDR_W | Index register value |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Instruction in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| rf_we | output | 1 | Register copy strobe |
| rf_sel | output | 3 | Register code |
| rf_wdata | output | 8 | Register copy value |
| flags_we | output | 1 | Flag update strobe |
| flags_out | output | 8 | New flag byte |
| done | output | 1 | Instruction complete (one cycle) |

## Verification
The bench builds the unit with the default ADDR_W of 16. At that width, both the wrap of the address sum past the top of the space and a read-only upper half are reachable, so a discarded write can be compared with the register copy. Every one of the 256 operation bytes runs against several operand values, carry settings and acknowledge latencies. This sweeps all shift kinds, all bit indices and all eight register codes. Expected results and flags are computed arithmetically from the requirements.

// File: rtl/xbit_pkg.sv
package xbit_pkg;
  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLR   = 2'b10,
    CLS_SET   = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE
  } seq_state_e;

  localparam logic [2:0] SEL_MEM_ONLY = 3'b110;
endpackage

// File: rtl/xbit_alu.sv
module xbit_alu
  import xbit_pkg::*;
(
  input  logic [7:0] op,
  input  logic [7:0] din,
  input  logic       cin,
  output logic [7:0] res,
  output logic [7:0] flags,
  output logic       flags_upd,
  output logic       mem_upd
);
  op_class_e  cls;
  logic [2:0] idx;
  logic [7:0] mask;
  logic       cout;
  logic       tbit;

  assign cls  = op_class_e'(op[7:6]);
  assign idx  = op[5:3];
  assign mask = 8'(1) << idx;
  assign tbit = |(din & mask);

  always_comb begin
    res       = din;
    cout      = cin;
    flags     = 8'h00;
    flags_upd = 1'b0;
    mem_upd   = 1'b1;
    unique case (cls)
      CLS_SHIFT: begin
        case (idx)
          3'd0: begin res = {din[6:0], din[7]}; cout = din[7]; end
          3'd1: begin res = {din[0], din[7:1]}; cout = din[0]; end
          3'd2: begin res = {din[6:0], cin};    cout = din[7]; end
          3'd3: begin res = {cin, din[7:1]};    cout = din[0]; end
          3'd4: begin res = {din[6:0], 1'b0};   cout = din[7]; end
          3'd5: begin res = {din[7], din[7:1]}; cout = din[0]; end
          3'd6: begin res = {din[6:0], 1'b1};   cout = din[7]; end
          default: begin res = {1'b0, din[7:1]}; cout = din[0]; end
        endcase
        flags = {res[7], (res == 8'h00), res[5], 1'b0, res[3], ~^res, 1'b0, cout};
        flags_upd = 1'b1;
      end
      CLS_TEST: begin
        mem_upd   = 1'b0;
        flags_upd = 1'b1;
        flags = {(idx == 3'd7) & tbit, ~tbit, 1'b0, 1'b1, 1'b0, ~tbit, 1'b0, cin};
      end
      CLS_CLR: res = din & ~mask;
      default: res = din | mask;
    endcase
  end
endmodule

// File: rtl/xbit_seq.sv
module xbit_seq
  import xbit_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        op_in,
  input  logic [7:0]        disp_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              cin_in,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        alu_res,
  input  logic [7:0]        alu_flags,
  input  logic              alu_flags_upd,
  input  logic              alu_mem_upd,
  output logic [7:0]        op_q,
  output logic [7:0]        din_q,
  output logic              cin_q,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rf_we,
  output logic [2:0]        rf_sel,
  output logic [7:0]        rf_wdata,
  output logic              flags_we,
  output logic [7:0]        flags_out,
  output logic              done
);
  localparam int EXT_W = ADDR_W - 8;

  seq_state_e        state;
  logic [ADDR_W-1:0] eff_addr;

  assign eff_addr = base_in + {{EXT_W{disp_in[7]}}, disp_in};
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= 8'h00;
      din_q     <= 8'h00;
      cin_q     <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 8'h00;
      rf_we     <= 1'b0;
      rf_sel    <= 3'b000;
      rf_wdata  <= 8'h00;
      flags_we  <= 1'b0;
      flags_out <= 8'h00;
      done      <= 1'b0;
    end else begin
      rf_we    <= 1'b0;
      flags_we <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q     <= op_in;
          cin_q    <= cin_in;
          mem_addr <= eff_addr;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          state    <= ST_READ;
        end
        ST_READ: if (mem_ack) begin
          mem_req <= 1'b0;
          din_q   <= mem_rdata;
          state   <= ST_CALC;
        end
        ST_CALC: begin
          if (alu_mem_upd) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= alu_res;
            state     <= ST_WRITE;
          end else begin
            flags_we  <= alu_flags_upd;
            flags_out <= alu_flags;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: if (mem_ack) begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          done      <= 1'b1;
          flags_we  <= alu_flags_upd;
          if (alu_flags_upd) flags_out <= alu_flags;
          if (op_q[2:0] != SEL_MEM_ONLY) begin
            rf_we    <= 1'b1;
            rf_sel   <= op_q[2:0];
            rf_wdata <= mem_wdata;
          end
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/xbit_unit.sv
module xbit_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        op_byte,
  input  logic [7:0]        disp_byte,
  input  logic [ADDR_W-1:0] index_base,
  input  logic              carry_in,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              rf_we,
  output logic [2:0]        rf_sel,
  output logic [7:0]        rf_wdata,
  output logic              flags_we,
  output logic [7:0]        flags_out,
  output logic              done
);
  logic [7:0] op_q;
  logic [7:0] din_q;
  logic       cin_q;
  logic [7:0] alu_res;
  logic [7:0] alu_flags;
  logic       alu_flags_upd;
  logic       alu_mem_upd;

  xbit_alu u_alu (
    .op        (op_q),
    .din       (din_q),
    .cin       (cin_q),
    .res       (alu_res),
    .flags     (alu_flags),
    .flags_upd (alu_flags_upd),
    .mem_upd   (alu_mem_upd)
  );

  xbit_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .op_in         (op_byte),
    .disp_in       (disp_byte),
    .base_in       (index_base),
    .cin_in        (carry_in),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .alu_res       (alu_res),
    .alu_flags     (alu_flags),
    .alu_flags_upd (alu_flags_upd),
    .alu_mem_upd   (alu_mem_upd),
    .op_q          (op_q),
    .din_q         (din_q),
    .cin_q         (cin_q),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .rf_we         (rf_we),
    .rf_sel        (rf_sel),
    .rf_wdata      (rf_wdata),
    .flags_we      (flags_we),
    .flags_out     (flags_out),
    .done          (done)
  );
endmodule

// File: rtl/xbit_unit_chk.sv
module xbit_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack,
  input logic              rf_we,
  input logic [2:0]        rf_sel,
  input logic              flags_we,
  input logic              done,
  input logic [7:0]        op_q
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r1_read_first: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (mem_req && !mem_we));

  a_r6_no_copy_mem_only: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_sel != 3'b110));

  a_r5_copy_with_done: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);

  a_r7_test_no_write: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q[7:6] == 2'b01) |-> !mem_we);

  a_r7_test_no_copy: assert property (@(posedge clk) disable iff (rst)
    (done && op_q[7:6] == 2'b01) |-> !rf_we);

  a_r9_no_flags_setres: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (!op_q[7] && done));

  a_r4_done_releases: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
endmodule

bind xbit_unit xbit_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .rf_we     (rf_we),
  .rf_sel    (rf_sel),
  .flags_we  (flags_we),
  .done      (done),
  .op_q      (op_q)
);

// File: tb/xbit_unit_tb.sv
module xbit_unit_tb;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [7:0]        op_byte = 8'h00;
  logic [7:0]        disp_byte = 8'h00;
  logic [ADDR_W-1:0] index_base = '0;
  logic              carry_in = 1'b0;
  logic              busy, mem_req, mem_we, rf_we, flags_we, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, rf_wdata, flags_out;
  logic [7:0]        mem_rdata = 8'h00;
  logic              mem_ack = 1'b0;
  logic [2:0]        rf_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] mem [0:255];
  int ack_lat = 0;
  int lat_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  xbit_unit #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_byte(op_byte), .disp_byte(disp_byte),
    .index_base(index_base), .carry_in(carry_in), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata),
    .flags_we(flags_we), .flags_out(flags_out), .done(done)
  );

  // memory model: upper half of the address space is read-only
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt >= ack_lat) begin
        mem_ack <= 1'b1;
        lat_cnt <= 0;
        if (mem_we) begin
          wr_cnt  <= wr_cnt + 1;
          wr_addr <= mem_addr;
          wr_data <= mem_wdata;
          if (!mem_addr[ADDR_W-1]) mem[mem_addr[7:0]] <= mem_wdata;
        end else begin
          rd_cnt    <= rd_cnt + 1;
          rd_addr   <= mem_addr;
          mem_rdata <= mem[mem_addr[7:0]];
        end
      end else lat_cnt <= lat_cnt + 1;
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] op, input logic [7:0] d, input bit c,
                                output logic [7:0] r, output logic [7:0] f);
    int k = int'(op[5:3]);
    int v = int'(d);
    int co = int'(c);
    int par;
    r = d;
    f = 8'h00;
    case (op[7:6])
      2'b00: begin
        case (k)
          0: begin co = v / 128;    v = (v * 2 + v / 128) % 256; end
          1: begin co = v % 2;      v = v / 2 + (v % 2) * 128; end
          2: begin co = v / 128;    v = (v * 2 + int'(c)) % 256; end
          3: begin co = v % 2;      v = v / 2 + int'(c) * 128; end
          4: begin co = v / 128;    v = (v * 2) % 256; end
          5: begin co = v % 2;      v = v / 2 + (v / 128) * 128; end
          6: begin co = v / 128;    v = (v * 2 + 1) % 256; end
          default: begin co = v % 2; v = v / 2; end
        endcase
        r = 8'(v);
        par = 0;
        for (int b = 0; b < 8; b++) par += (v >> b) & 1;
        f = 8'(((v / 128) * 128) + ((v == 0) ? 64 : 0) + (v & 32) + (v & 8) +
               ((par % 2 == 0) ? 4 : 0) + co);
      end
      2'b01: begin
        int t = (v >> k) & 1;
        f = 8'(((k == 7 && t == 1) ? 128 : 0) + ((t == 0) ? 64 : 0) + 16 +
               ((t == 0) ? 4 : 0) + int'(c));
      end
      2'b10: r = 8'(v & (255 - (1 << k)));
      default: r = 8'(v | (1 << k));
    endcase
  endfunction

  task automatic run_one(input logic [7:0] op, input logic [7:0] disp, input logic [ADDR_W-1:0] base,
                         input logic [7:0] data, input bit c, input int lat, input bit inject);
    logic [ADDR_W-1:0] ea;
    logic [7:0] er, ef;
    bit got = 0;
    bit wr_exp;
    ea = base + {{(ADDR_W-8){disp[7]}}, disp};
    model(op, data, c, er, ef);
    wr_exp = (op[7:6] != 2'b01);
    @(negedge clk);
    mem[ea[7:0]] = data;
    rd_cnt = 0; wr_cnt = 0; ack_lat = lat;
    op_byte = op; disp_byte = disp; index_base = base; carry_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      chk(busy === 1'b1, "R10 busy", int'(busy), 1);
      op_byte = ~op; disp_byte = disp + 8'd1; carry_in = ~c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 60; w++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R4 done", int'(got), 1);
    if (!got) return;
    chk(rd_cnt == 1 && rd_addr == ea, "R1 read addr", int'(rd_addr), int'(ea));
    if (wr_exp)
      chk(wr_cnt == 1 && wr_addr == ea && wr_data == er, "R2 R3 R4 write", int'(wr_data), int'(er));
    else
      chk(wr_cnt == 0, "R7 test no write", wr_cnt, 0);
    if (!wr_exp || op[2:0] == 3'b110)
      chk(rf_we == 1'b0, "R6 R7 no copy", int'(rf_we), 0);
    else
      chk(rf_we && rf_sel == op[2:0] && rf_wdata == er, "R5 copy",
          int'({rf_we, rf_sel, rf_wdata}), int'({1'b1, op[2:0], er}));
    if (op[7:6] == 2'b00)
      chk(flags_we && flags_out == ef, "R8 shift flags", int'(flags_out), int'(ef));
    else if (op[7:6] == 2'b01)
      chk(flags_we && flags_out == ef, "R7 test flags", int'(flags_out), int'(ef));
    else
      chk(!flags_we, "R9 no flags", int'(flags_we), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !rf_we && !flags_we && !done, "R11 reset",
        int'({busy, mem_req, rf_we, flags_we, done}), 0);
    rst = 1'b0;
    // R2 R3 R5 R6 R7 R8 R9 sweep over every operation byte
    for (int o = 0; o < 256; o++) begin
      for (int di = 0; di < 6; di++) begin
        logic [7:0] dv;
        case (di)
          0: dv = 8'h00; 1: dv = 8'h01; 2: dv = 8'h80;
          3: dv = 8'hA5; 4: dv = 8'h5A; default: dv = 8'hFF;
        endcase
        run_one(8'(o), 8'(o * 7 + di), 16'h0100, dv, bit'((o + di) % 2), (o + di) % 3, 1'b0);
      end
    end
    // R5: write to read-only region discarded, register still gets rotated value
    run_one(8'h00, 8'h05, 16'h8000, 8'h81, 1'b0, 1, 1'b0);
    chk(mem[8'h05] == 8'h81, "R5 rom unchanged", int'(mem[8'h05]), 8'h81);
    // R1: address wrap in both directions
    run_one(8'hC7, 8'h20, 16'hFFF0, 8'h10, 1'b0, 0, 1'b0);
    run_one(8'h3F, 8'hF0, 16'h0005, 8'h42, 1'b1, 2, 1'b0);
    // R10: start while busy is ignored
    run_one(8'hC7, 8'h03, 16'h0040, 8'h10, 1'b0, 2, 1'b1);
    run_one(8'h12, 8'h83, 16'h0200, 8'h96, 1'b1, 0, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule